// File: doc/BRIEF.md
# Multi-Mode Transmit Phase FIFO

This block sits on the transmit path between a fabric-side producer and a transceiver-side consumer that share one clock. A write port (data plus valid) feeds it, and a read port delivers data plus valid. The consumer pulls words with a read request. A static two-bit mode input picks one of four behaviours:

- A standard eight-entry FIFO.
- A shallow low-latency FIFO. It is capped at four entries and holds reads back until two words are buffered, which fixes its latency window.
- A register mode. Storage is skipped and input reaches output after one clock.
- A fast register mode. Storage is skipped and a second register stage is added for timing, giving two clocks.

In both FIFO modes, a write when full and a read when empty are dropped. Each such event sets a sticky overflow or underflow flag that only reset clears. The mode is set up while reset is held and must not change afterwards.

Top module: `tx_phase_fifo`

## Requirements
- R1: While reset is asserted and on release, rd_valid, full, overflow and underflow are 0 and empty is 1, in every mode.
- R2: In standard mode (mode = 0), a read request while empty is 0 pops the oldest word. rd_valid is 1 with that word on rd_data in the following cycle, and words leave in write order. With no accepted read, rd_valid is 0.
- R3: In standard mode, full is 1 exactly when 8 words are held, and empty is 1 exactly when 0 words are held.
- R4: In either FIFO mode, a write while full is dropped: the stored contents and later read data are unchanged. It sets overflow, which stays 1 until reset.
- R5: In either FIFO mode, a read request while empty is ignored: rd_valid is 0 in the next cycle. It sets underflow, which stays 1 until reset.
- R6: In low-latency mode (mode = 1), full is 1 exactly when 4 words are held.
- R7: In low-latency mode, empty stays 1 from an occupancy of 0 until the occupancy reaches 2. From then on, reads are served until the occupancy returns to 0, where the wait for 2 words starts again. Otherwise reads behave as in R2.
- R8: In register mode (mode = 2), rd_valid and rd_data equal wr_valid and wr_data of the previous cycle, and rd_req is ignored.
- R9: In fast register mode (mode = 3), rd_valid and rd_data equal wr_valid and wr_data of two cycles earlier, and rd_req is ignored.
- R10: The mode input changes only while reset is asserted.
- R11: In both register modes, full, overflow and underflow stay 0 and empty stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared write/read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 standard, 1 low-latency, 2 register, 3 fast register |
| wr_valid | input | 1 | Write strobe |
| wr_data | input | W | Write word |
| rd_req | input | 1 | Read request (FIFO modes) |
| rd_valid | output | 1 | Output word valid |
| rd_data | output | W | Output word |
| full | output | 1 | No room for a write |
| empty | output | 1 | No read would be served |
| overflow | output | 1 | Sticky: write dropped while full |
| underflow | output | 1 | Sticky: read refused while empty |

## Verification
In the FIFO modes, full and empty follow the occupancy left by the previous clock edge. A read accepted at one edge shows up on rd_valid and rd_data straight after that edge. In register mode, output trails input by one edge; in fast register mode it trails by two. The bench drives inputs and samples outputs at the falling edge. At each falling edge it first compares the outputs against a model advanced once per rising edge, then chooses new inputs and advances the model. Every compare therefore lands exactly one edge after the stimulus it depends on.

// File: rtl/txpf_pkg.sv
package txpf_pkg;
  typedef enum logic [1:0] {
    TXPF_STD     = 2'd0,
    TXPF_LOWLAT  = 2'd1,
    TXPF_REG     = 2'd2,
    TXPF_FASTREG = 2'd3
  } txpf_mode_e;
endpackage

// File: rtl/txpf_ctrl.sv
module txpf_ctrl
  import txpf_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int LL_DEPTH = 4,
  parameter int LL_START = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  txpf_mode_e    mode,
  input  logic          wr_valid,
  input  logic          rd_req,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          full,
  output logic          empty,
  output logic          overflow,
  output logic          underflow
);
  logic [CW-1:0] cnt_q, cnt_d, cap;
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic          primed_q, primed_d, ovf_q, ovf_d, udf_q, udf_d;
  logic          fifo_on, ll_on;

  // next-state logic
  always_comb begin
    fifo_on = (mode == TXPF_STD) || (mode == TXPF_LOWLAT);
    ll_on   = (mode == TXPF_LOWLAT);
    cap     = ll_on ? CW'(LL_DEPTH) : CW'(DEPTH);
    full    = fifo_on && (cnt_q == cap);
    empty   = !fifo_on || (cnt_q == '0) || (ll_on && !primed_q);
    wr_en   = fifo_on && wr_valid && !full;
    rd_en   = fifo_on && rd_req && !empty;
    cnt_d   = cnt_q + CW'(wr_en) - CW'(rd_en);
    wptr_d  = wptr_q;
    if (wr_en) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    rptr_d  = rptr_q;
    if (rd_en) rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    primed_d = ll_on && ((cnt_d >= CW'(LL_START)) || (primed_q && (cnt_d != '0)));
    ovf_d    = ovf_q | (fifo_on & wr_valid & full);
    udf_d    = udf_q | (fifo_on & rd_req & empty);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      wptr_q   <= '0;
      rptr_q   <= '0;
      primed_q <= 1'b0;
      ovf_q    <= 1'b0;
      udf_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      wptr_q   <= wptr_d;
      rptr_q   <= rptr_d;
      primed_q <= primed_d;
      ovf_q    <= ovf_d;
      udf_q    <= udf_d;
    end
  end

  assign wptr      = wptr_q;
  assign rptr      = rptr_q;
  assign overflow  = ovf_q;
  assign underflow = udf_q;
endmodule

// File: rtl/txpf_mem.sv
module txpf_mem #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = we && (waddr == AW'(i));
    always_ff @(posedge clk) begin
      if (slot_en) slot[i] <= wdata;
    end
  end

  assign rdata = slot[raddr];
endmodule

// File: rtl/txpf_out.sv
module txpf_out
  import txpf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  txpf_mode_e   mode,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         pop,
  input  logic [W-1:0] pop_data,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  logic         s1_v_q, s1_v_d, s1_en;
  logic [W-1:0] s1_d_q, s1_d_d;
  logic         o_v_q, o_v_d;
  logic [W-1:0] o_d_q, o_d_d;

  always_comb begin
    s1_en  = (mode == TXPF_FASTREG);
    s1_v_d = s1_en ? wr_valid : s1_v_q;
    s1_d_d = s1_en ? wr_data  : s1_d_q;
    unique case (mode)
      TXPF_REG: begin
        o_v_d = wr_valid;
        o_d_d = wr_data;
      end
      TXPF_FASTREG: begin
        o_v_d = s1_v_q;
        o_d_d = s1_d_q;
      end
      default: begin
        o_v_d = pop;
        o_d_d = pop ? pop_data : o_d_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v_q <= 1'b0;
      s1_d_q <= '0;
      o_v_q  <= 1'b0;
      o_d_q  <= '0;
    end else begin
      s1_v_q <= s1_v_d;
      s1_d_q <= s1_d_d;
      o_v_q  <= o_v_d;
      o_d_q  <= o_d_d;
    end
  end

  assign rd_valid = o_v_q;
  assign rd_data  = o_d_q;
endmodule

// File: rtl/tx_phase_fifo.sv
module tx_phase_fifo
  import txpf_pkg::*;
#(
  parameter int W        = 8,
  parameter int DEPTH    = 8,
  parameter int LL_DEPTH = 4,
  parameter int LL_START = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty,
  output logic         overflow,
  output logic         underflow
);
  localparam int AW = $clog2(DEPTH);

  txpf_mode_e    mode_e;
  logic          wr_en, rd_en;
  logic [AW-1:0] wptr, rptr;
  logic [W-1:0]  head_word;

  assign mode_e = txpf_mode_e'(mode);

  txpf_ctrl #(.DEPTH(DEPTH), .LL_DEPTH(LL_DEPTH), .LL_START(LL_START)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .wr_valid(wr_valid), .rd_req(rd_req),
    .wr_en(wr_en), .rd_en(rd_en), .wptr(wptr), .rptr(rptr), .full(full),
    .empty(empty), .overflow(overflow), .underflow(underflow)
  );

  txpf_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wptr), .wdata(wr_data), .raddr(rptr), .rdata(head_word)
  );

  txpf_out #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .wr_valid(wr_valid), .wr_data(wr_data),
    .pop(rd_en), .pop_data(head_word), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/tx_phase_fifo_chk.sv
module tx_phase_fifo_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic         wr_valid,
  input logic [W-1:0] wr_data,
  input logic         rd_req,
  input logic         rd_valid,
  input logic [W-1:0] rd_data,
  input logic         full,
  input logic         empty,
  input logic         overflow,
  input logic         underflow
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |-> (!rd_valid && !full && empty && !overflow && !underflow));

  a_r2_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && rd_req && !empty) |=> rd_valid);

  a_r2_no_valid_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && !rd_req) |=> !rd_valid);

  a_r3_full_empty_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  a_r4_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && wr_valid && full) |=> overflow);

  a_r4_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r5_underflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && rd_req && empty) |=> (underflow && !rd_valid));

  a_r5_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  a_r8_reg_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |=> (rd_valid == $past(wr_valid) && rd_data == $past(wr_data)));

  a_r9_fastreg_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && $past(rst_n)) |=>
      (rd_valid == $past(wr_valid, 2) && rd_data == $past(wr_data, 2)));

  a_r10_mode_static: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode));

  a_r11_reg_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |-> (!full && empty && !overflow && !underflow));
endmodule

bind tx_phase_fifo tx_phase_fifo_chk #(.W(W)) u_chk (.*);

// File: tb/tx_phase_fifo_tb.sv
`timescale 1ns/1ps
module tx_phase_fifo_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   mode;
  logic         wr_valid, rd_req;
  logic [W-1:0] wr_data;
  logic         rd_valid, full, empty, overflow, underflow;
  logic [W-1:0] rd_data;

  always #2 clk = ~clk;

  tx_phase_fifo #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .full(full),
    .empty(empty), .overflow(overflow), .underflow(underflow)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state
  int           m_cnt;
  bit           m_primed, m_ovf, m_udf, m_v, m_s1v;
  logic [W-1:0] m_d, m_s1d;
  logic [W-1:0] m_q[$];

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // mode is only ever changed here, with reset held low (R10)
  task automatic reset_to(logic [1:0] m);
    rst_n = 1'b0; mode = m; wr_valid = 1'b0; rd_req = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R1", "rd_valid", W'(rd_valid), '0);
    chk("R1", "full", W'(full), '0);
    chk("R1", "empty", W'(empty), W'(1));
    chk("R1", "overflow", W'(overflow), '0);
    chk("R1", "underflow", W'(underflow), '0);
    rst_n = 1'b1;
    m_cnt = 0; m_primed = 0; m_ovf = 0; m_udf = 0; m_v = 0; m_d = '0;
    m_s1v = 0; m_s1d = '0; m_q.delete();
  endtask

  task automatic run(int n, int wp, int rp);
    for (int i = 0; i < n; i++) begin
      bit fifo, ll, fl, em, w, r, pop, push;
      logic [W-1:0] d;
      int cap;
      string vtag;
      fifo = !mode[1];
      ll   = (mode == 2'd1);
      cap  = ll ? 4 : 8;
      fl   = fifo && (m_cnt == cap);
      em   = !fifo || (m_cnt == 0) || (ll && !m_primed);
      vtag = (mode == 2'd0) ? "R2" : (mode == 2'd1) ? "R7" : (mode == 2'd2) ? "R8" : "R9";
      // compare outputs produced by the previous rising edge
      chk(ll ? "R6" : (fifo ? "R3" : "R11"), "full", W'(full), W'(fl));
      chk(ll ? "R7" : (fifo ? "R3" : "R11"), "empty", W'(empty), W'(em));
      chk(fifo ? "R4" : "R11", "overflow", W'(overflow), W'(m_ovf));
      chk(fifo ? "R5" : "R11", "underflow", W'(underflow), W'(m_udf));
      chk(vtag, "rd_valid", W'(rd_valid), W'(m_v));
      if (m_v) chk(vtag, "rd_data", rd_data, m_d);
      // new stimulus
      w = ($urandom_range(99) < wp);
      r = ($urandom_range(99) < rp);
      d = W'($urandom);
      wr_valid = w; rd_req = r; wr_data = d;
      // advance model across the coming rising edge
      if (fifo) begin
        pop  = r && !em;
        push = w && !fl;
        if (w && fl) m_ovf = 1;
        if (r && em) m_udf = 1;
        m_v = pop;
        if (pop) m_d = m_q.pop_front();
        if (push) m_q.push_back(d);
        m_cnt = m_cnt + int'(push) - int'(pop);
        if (ll) m_primed = (m_cnt >= 2) || (m_primed && m_cnt != 0);
      end else if (mode == 2'd2) begin
        m_v = w; m_d = d;
      end else begin
        m_v = m_s1v; m_d = m_s1d; m_s1v = w; m_s1d = d;
      end
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    for (int m = 0; m < 4; m++) begin
      reset_to(2'(m));
      run(200, 90, 10);   // fill and overrun (R4, R3/R6 full)
      run(200, 10, 90);   // drain and underrun (R5, R7 priming)
      run(300, 50, 50);   // mixed traffic (R2, R8, R9)
      run(100, 100, 100); // back-to-back both ports
      run(100, 0, 0);     // idle
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule